// File: doc/BRIEF.md
# Clock Prescaler Pair Selector

This block turns a required clock division ratio into a pair of divider field indices for a serial-bus clock generator that divides by the product of two table values: a small prescaler and a large scaler. The caller supplies the ratio as a dividend and a divisor. For a bit-rate setting these are the input clock frequency and the wanted bit rate. For a chip-select timing gap they are the gap length in nanoseconds times the clock frequency, and one billion. The block rounds the quotient up, giving the minimum acceptable divisor. It then searches the tables for the smallest product that is not below that minimum.

Two table sets are available, chosen per request by a mode input. In bit-rate mode the prescaler is a small prime and the scaler grows almost geometrically. In timing-gap mode the prescaler is odd and the scaler is a pure power of two. The search follows a fixed order, so when two pairs give the same product the winner is always the same one. If no pair is large enough, the block returns the largest indices and raises a flag. Each request is a single start pulse, and the block answers with a single done pulse.

Top module: `psel_top`

## Requirements
- R1: The requirement is ceil(dividend / divisor): the integer quotient, plus one when the division leaves a nonzero remainder. A zero divisor makes the requirement larger than any product, so the result falls back (R6).
- R2: With mode = 0 (bit-rate), prescaler index 0..3 selects 2, 3, 5, 7. Scaler index 0, 1, 2 selects 2, 4, 6, and scaler index k >= 3 selects 2^k (8 up to 32768).
- R3: With mode = 1 (timing gap), prescaler index i selects 2*i+1 (1, 3, 5, 7) and scaler index k selects 2^(k+1) (2 up to 65536).
- R4: The chosen pair has the smallest product that is greater than or equal to the requirement. In mode 0 the outer scan runs over scaler indices in ascending order and the inner scan over prescaler indices in ascending order. Each inner scan stops at its first product that meets the requirement, and that pair replaces the kept pair only if its product is strictly smaller. Example: requirement 12 gives prescaler 1, scaler 1.
- R5: In mode 1 the outer scan runs over prescaler indices and the inner scan over scaler indices, both ascending, with the same stop and replace rules as R4.
- R6: When no pair reaches the requirement, the outputs are prescaler index 3 and scaler index 15 with fallback = 1. Otherwise fallback = 0, including when the requirement exactly equals the largest product.
- R7: A requirement of 0 or 1 gives prescaler index 0 and scaler index 0 with fallback = 0.
- R8: Every accepted start produces exactly one done pulse, one cycle long. The index and fallback outputs keep their values until the next done.
- R9: A start that arrives while a request is in progress is ignored. It changes neither the result nor the number of done pulses.
- R10: After reset, done = 0, fallback = 0 and both indices are 0.
- R11: The division takes NUM_W cycles. The search then examines one candidate per cycle, at most 64 in total, so done arrives no more than NUM_W + 70 cycles after start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; sampled only when idle |
| mode | input | 1 | 0 = bit-rate tables, 1 = timing-gap tables |
| ratio_num | input | NUM_W | Dividend of the required ratio |
| ratio_den | input | DEN_W | Divisor of the required ratio |
| done | output | 1 | One-cycle result strobe |
| pre_idx | output | 2 | Chosen prescaler index |
| scl_idx | output | 4 | Chosen scaler index |
| fallback | output | 1 | No pair reached the requirement |

## Verification
The in-RTL assertions check several properties on every cycle. Done never lasts two cycles, and the divider signals completion only right after a busy cycle. The scan counters stay inside the active table sizes, and the stored mode cannot change while a request is in progress. Any result delivered without fallback has a product at least as large as the requirement, and a requirement of 0 or 1 always maps to the zero pair. What only the bench scenarios can show are the exact values: rounding up on a remainder, the tie resolved by scan order, the limits on either side of the largest product in each mode, the zero divisor, and a start ignored during a search.

// File: rtl/psel_pkg.sv
package psel_pkg;

  localparam int PROD_W = 20;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_SRCH = 2'd2
  } psel_state_e;

  function automatic logic [PROD_W-1:0] pre_value(input logic gap_mode,
                                                  input logic [1:0] idx);
    if (gap_mode) return PROD_W'({idx, 1'b1});
    case (idx)
      2'd0:    return PROD_W'(2);
      2'd1:    return PROD_W'(3);
      2'd2:    return PROD_W'(5);
      default: return PROD_W'(7);
    endcase
  endfunction

  function automatic logic [PROD_W-1:0] scl_value(input logic gap_mode,
                                                  input logic [3:0] idx);
    if (gap_mode) return PROD_W'(2) << idx;
    if (idx < 4'd3) return PROD_W'({idx, 1'b0}) + PROD_W'(2);
    return PROD_W'(1) << idx;
  endfunction

  function automatic logic [PROD_W-1:0] pair_product(input logic gap_mode,
                                                     input logic [1:0] p,
                                                     input logic [3:0] s);
    return pre_value(gap_mode, p) * scl_value(gap_mode, s);
  endfunction

endpackage

// File: rtl/psel_ceil_div.sv
module psel_ceil_div #(
  parameter int NUM_W = 48,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W:0]   result
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] quo_q, quo_d;
  logic [DEN_W-1:0] rem_q, rem_d, den_q, den_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d, done_q, done_d;
  logic [DEN_W:0]   shifted;
  logic [DEN_W-1:0] diff;
  logic             step_en;

  assign step_en = busy_q | start;

  always_comb begin
    shifted = {rem_q, quo_q[NUM_W-1]};
    diff    = shifted[DEN_W-1:0] - den_q;
    quo_d   = quo_q;
    rem_d   = rem_q;
    den_d   = den_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    if (busy_q) begin
      if (shifted >= {1'b0, den_q}) begin
        rem_d = diff;
        quo_d = {quo_q[NUM_W-2:0], 1'b1};
      end else begin
        rem_d = shifted[DEN_W-1:0];
        quo_d = {quo_q[NUM_W-2:0], 1'b0};
      end
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(NUM_W - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end else if (start) begin
      quo_d  = num;
      rem_d  = '0;
      den_d  = den;
      cnt_d  = '0;
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (step_en) begin
        quo_q  <= quo_d;
        rem_q  <= rem_d;
        den_q  <= den_d;
        cnt_q  <= cnt_d;
        busy_q <= busy_d;
      end
    end
  end

  assign done   = done_q;
  assign result = {1'b0, quo_q} + (NUM_W+1)'(rem_q != '0);

  // R1 / R11: completion only directly after the last busy step
  p_div_done_after_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));

endmodule

// File: rtl/psel_pair_search.sv
module psel_pair_search
  import psel_pkg::*;
#(
  parameter int REQ_W = 49
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic [REQ_W-1:0] req,
  output logic             done,
  output logic [1:0]       pre_idx,
  output logic [3:0]       scl_idx,
  output logic             fallback
);
  localparam int PAD_W = REQ_W - PROD_W;

  logic             active_q, active_d, mode_q, mode_d, found_q, found_d;
  logic [REQ_W-1:0] req_q, req_d;
  logic [3:0]       out_q, out_d, in_q, in_d, out_last, in_last;
  logic [PROD_W-1:0] best_q, best_d, prod;
  logic [1:0]       bpre_q, bpre_d, cur_pre, pre_o_q, pre_o_d;
  logic [3:0]       bscl_q, bscl_d, cur_scl, scl_o_q, scl_o_d;
  logic             done_q, done_d, fb_q, fb_d, met, run_en;

  assign out_last = mode_q ? 4'd3  : 4'd15;
  assign in_last  = mode_q ? 4'd15 : 4'd3;
  assign cur_pre  = mode_q ? out_q[1:0] : in_q[1:0];
  assign cur_scl  = mode_q ? in_q : out_q;
  assign prod     = pair_product(mode_q, cur_pre, cur_scl);
  assign met      = {{PAD_W{1'b0}}, prod} >= req_q;
  assign run_en   = active_q | start;

  always_comb begin
    active_d = active_q;
    mode_d   = mode_q;
    req_d    = req_q;
    out_d    = out_q;
    in_d     = in_q;
    best_d   = best_q;
    found_d  = found_q;
    bpre_d   = bpre_q;
    bscl_d   = bscl_q;
    pre_o_d  = pre_o_q;
    scl_o_d  = scl_o_q;
    fb_d     = fb_q;
    done_d   = 1'b0;
    if (active_q) begin
      if (met && (!found_q || prod < best_q)) begin
        best_d  = prod;
        bpre_d  = cur_pre;
        bscl_d  = cur_scl;
        found_d = 1'b1;
      end
      if (met || in_q == in_last) begin
        in_d = '0;
        if (out_q == out_last) begin
          active_d = 1'b0;
          done_d   = 1'b1;
          pre_o_d  = found_d ? bpre_d : 2'd3;
          scl_o_d  = found_d ? bscl_d : 4'd15;
          fb_d     = !found_d;
        end else begin
          out_d = out_q + 1'b1;
        end
      end else begin
        in_d = in_q + 1'b1;
      end
    end else if (start) begin
      active_d = 1'b1;
      mode_d   = mode;
      req_d    = req;
      out_d    = '0;
      in_d     = '0;
      best_d   = '1;
      found_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      mode_q   <= 1'b0;
      req_q    <= '0;
      out_q    <= '0;
      in_q     <= '0;
      best_q   <= '1;
      found_q  <= 1'b0;
      bpre_q   <= '0;
      bscl_q   <= '0;
      pre_o_q  <= '0;
      scl_o_q  <= '0;
      fb_q     <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= done_d;
      if (run_en) begin
        active_q <= active_d;
        mode_q   <= mode_d;
        req_q    <= req_d;
        out_q    <= out_d;
        in_q     <= in_d;
        best_q   <= best_d;
        found_q  <= found_d;
        bpre_q   <= bpre_d;
        bscl_q   <= bscl_d;
        pre_o_q  <= pre_o_d;
        scl_o_q  <= scl_o_d;
        fb_q     <= fb_d;
      end
    end
  end

  assign done     = done_q;
  assign pre_idx  = pre_o_q;
  assign scl_idx  = scl_o_q;
  assign fallback = fb_q;

  // R8: done is a single-cycle strobe
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R4: a non-fallback result always covers the requirement
  p_result_meets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !fb_q) |-> ({{PAD_W{1'b0}}, pair_product(mode_q, pre_o_q, scl_o_q)} >= req_q));

  // R7: trivial requirements map to the zero pair
  p_small_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && req_q <= REQ_W'(1)) |-> (pre_o_q == 2'd0 && scl_o_q == 4'd0 && !fb_q));

  // R11: scan counters stay inside the active tables
  p_scan_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (out_q <= out_last && in_q <= in_last));

endmodule

// File: rtl/psel_top.sv
module psel_top
  import psel_pkg::*;
#(
  parameter int NUM_W = 48,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic [NUM_W-1:0] ratio_num,
  input  logic [DEN_W-1:0] ratio_den,
  output logic             done,
  output logic [1:0]       pre_idx,
  output logic [3:0]       scl_idx,
  output logic             fallback
);
  localparam int REQ_W = NUM_W + 1;

  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  psel_state_e      state_q, state_d;
  logic             mode_q, mode_d;
  logic             div_start, div_done, srch_start, srch_done;
  logic [REQ_W-1:0] req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  assign div_start  = (state_q == ST_IDLE) && start;
  assign srch_start = (state_q == ST_DIV) && div_done;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_DIV;
        mode_d  = mode;
      end
      ST_DIV:  if (div_done) state_d = ST_SRCH;
      ST_SRCH: if (srch_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (div_start) mode_q <= mode_d;
    end
  end

  psel_ceil_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .start  (div_start),
    .num    (ratio_num),
    .den    (ratio_den),
    .done   (div_done),
    .result (req)
  );

  psel_pair_search #(.REQ_W(REQ_W)) u_search (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .start    (srch_start),
    .mode     (mode_q),
    .req      (req),
    .done     (srch_done),
    .pre_idx  (pre_idx),
    .scl_idx  (scl_idx),
    .fallback (fallback)
  );

  assign done = srch_done;

  // R9: a start during a request cannot alter the stored mode
  p_mode_held_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (state_q != ST_IDLE) |=> $stable(mode_q));

  // R9: the divider finishes only for the request in progress
  p_single_job_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    div_done |-> (state_q == ST_DIV));

endmodule

// File: tb/sim_psel_top.sv
module sim_psel_top;
  localparam int  NUM_W  = 48;
  localparam int  DEN_W  = 32;
  localparam time CLK_T  = 10ns;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic             mode;
  logic [NUM_W-1:0] ratio_num;
  logic [DEN_W-1:0] ratio_den;
  logic             done;
  logic [1:0]       pre_idx;
  logic [3:0]       scl_idx;
  logic             fallback;

  int n_total = 0;
  int n_fail  = 0;

  always #(CLK_T/2) clk = ~clk;

  psel_top #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .ratio_num(ratio_num), .ratio_den(ratio_den),
    .done(done), .pre_idx(pre_idx), .scl_idx(scl_idx), .fallback(fallback)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint tb_pre(input bit m, input int i);
    longint t[4] = '{2, 3, 5, 7};
    if (m) return 2 * i + 1;
    return t[i];
  endfunction

  function automatic longint tb_scl(input bit m, input int k);
    if (m) return longint'(2) << k;
    if (k < 3) return 2 * (k + 1);
    return longint'(1) << k;
  endfunction

  function automatic longint ref_ceil(input longint num, input longint den);
    if (den == 0) return 64'h7fff_ffff_ffff_ffff;
    return (num + den - 1) / den;
  endfunction

  task automatic ref_pick(input bit m, input longint rq, output int p, output int s, output bit fb);
    longint best;
    bit     found;
    int     n_out;
    int     n_in;
    best  = 0;
    found = 0;
    p = 3;
    s = 15;
    n_out = m ? 4 : 16;
    n_in  = m ? 16 : 4;
    for (int o = 0; o < n_out; o++) begin
      for (int n = 0; n < n_in; n++) begin
        int     pi;
        int     si;
        longint pr;
        pi = m ? o : n;
        si = m ? n : o;
        pr = tb_pre(m, pi) * tb_scl(m, si);
        if (pr >= rq) begin
          if (!found || pr < best) begin
            best = pr; found = 1; p = pi; s = si;
          end
          break;
        end
      end
    end
    fb = !found;
  endtask

  task automatic launch(input bit m, input longint num, input longint den, output int lat);
    @(negedge clk);
    start = 1'b1; mode = m;
    ratio_num = NUM_W'(num); ratio_den = DEN_W'(den);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 400) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_expect(input string req, input bit m, input longint num, input longint den,
                            input int ep, input int es, input bit efb);
    int lat;
    launch(m, num, den, lat);
    chk(done == 1'b1, {req, " done"}, done, 1);
    chk(lat <= NUM_W + 70, "R11 latency", lat, NUM_W + 70);
    chk(pre_idx == ep[1:0], {req, " pre_idx"}, pre_idx, ep);
    chk(scl_idx == es[3:0], {req, " scl_idx"}, scl_idx, es);
    chk(fallback == efb, {req, " fallback"}, fallback, efb);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", done, 0);
  endtask

  task automatic run_model(input string req, input bit m, input longint num, input longint den);
    int p, s;
    bit fb;
    ref_pick(m, ref_ceil(num, den), p, s, fb);
    run_expect(req, m, num, den, p, s, fb);
  endtask

  task automatic t_reset;
    chk(done == 1'b0, "R10 done", done, 0);
    chk(fallback == 1'b0, "R10 fallback", fallback, 0);
    chk(pre_idx == 2'd0 && scl_idx == 4'd0, "R10 indices", {pre_idx, scl_idx}, 0);
  endtask

  task automatic t_rounding;
    run_expect("R1 exact", 1'b0, 100, 10, 2, 0, 1'b0);
    run_expect("R1 remainder", 1'b0, 101, 10, 1, 1, 1'b0);
  endtask

  task automatic t_baud;
    run_model("R2 100MHz/1MHz", 1'b0, 100_000_000, 1_000_000);
    run_model("R2 66MHz/25MHz", 1'b0, 66_000_000, 25_000_000);
    run_model("R2 120MHz/9600", 1'b0, 120_000_000, 9600);
    run_expect("R4 tie order", 1'b0, 12, 1, 1, 1, 1'b0);
  endtask

  task automatic t_delay;
    run_expect("R5 gap 7", 1'b1, 64'd6_650_000_000, 1_000_000_000, 0, 2, 1'b0);
    run_expect("R5 gap 9", 1'b1, 64'd9_000_000_000, 1_000_000_000, 2, 0, 1'b0);
    run_model("R3 gap 100ns@133MHz", 1'b1, 64'd13_300_000_000, 1_000_000_000);
    run_model("R3 gap 3000", 1'b1, 3000, 1);
  endtask

  task automatic t_limits;
    run_expect("R6 baud at max", 1'b0, 229376, 1, 3, 15, 1'b0);
    run_expect("R6 baud over", 1'b0, 229377, 1, 3, 15, 1'b1);
    run_expect("R6 gap at max", 1'b1, 458752, 1, 3, 15, 1'b0);
    run_expect("R6 gap over", 1'b1, 458753, 1, 3, 15, 1'b1);
    run_expect("R1 zero divisor", 1'b0, 5, 0, 3, 15, 1'b1);
  endtask

  task automatic t_small;
    run_expect("R7 req 0", 1'b0, 0, 5, 0, 0, 1'b0);
    run_expect("R7 req 1", 1'b1, 3, 3, 0, 0, 1'b0);
  endtask

  task automatic t_busy_ignore;
    int cyc;
    int pulses;
    @(negedge clk);
    start = 1'b1; mode = 1'b0; ratio_num = NUM_W'(12); ratio_den = DEN_W'(1);
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; mode = 1'b1; ratio_num = NUM_W'(458753); ratio_den = DEN_W'(1);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R9 first request done", done, 1);
    chk(pre_idx == 2'd1 && scl_idx == 4'd1, "R9 result unchanged", {pre_idx, scl_idx}, 6'h11);
    chk(fallback == 1'b0, "R9 fallback unchanged", fallback, 0);
    pulses = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (done) pulses++;
    end
    chk(pulses == 0, "R9 no extra done", pulses, 0);
    chk(pre_idx == 2'd1 && scl_idx == 4'd1, "R8 outputs held", {pre_idx, scl_idx}, 6'h11);
  endtask

  initial begin
    #(CLK_T * 150000);
    n_total++;
    n_fail++;
    $display("FAIL R11 watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 1'b0; ratio_num = '0; ratio_den = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rounding();
    t_baud();
    t_delay();
    t_limits();
    t_small();
    t_busy_ignore();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule